// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a virtual address into a physical address through a four-slot segment table. The two most significant address bits pick a slot and the remaining bits are the offset within that segment. Each slot holds a base address, a size, a direction flag and three access-permission bits. Slot 0 is meant for code, slot 1 for the heap and slot 2 for the stack. Slot 3 is a spare that can never translate.

A request carries the virtual address and an access kind. One clock later the unit returns a strobe, a physical address, a success flag and a fault code. An upward segment adds the offset to its base. A downward segment first subtracts the full segment span (2^offset-width) from the offset, which gives a negative displacement, and then adds that displacement to the base. The range check compares the offset, or for a downward segment the size of the displacement, against the slot size.

The table is loaded through a write port. That port takes effect only while the privilege input indicates kernel mode.

Top module: `segxl_top`

## Requirements
- R1: The top 2 bits of `req_vaddr` select the slot and the low VA_W-2 bits form the offset. Slot 3 always returns fault code 1 (bounds), whatever access kind is used and whatever was written to it.
- R2: In an upward slot with offset < size, the result is fault 0 and `rsp_paddr` = (base + offset) mod 2^PA_W.
- R3: In a downward slot (direction bit 1), with S = 2^(VA_W-2) and S - offset <= size, the result is fault 0 and `rsp_paddr` = (base + offset - S) mod 2^PA_W. Offset 0 is in range only when size equals S.
- R4: An access outside the slot's range returns fault code 1, `rsp_ok` = 0 and `rsp_paddr` = 0.
- R5: Access codes are 0 read, 1 write, 2 execute and 3 reserved. Permission bits are [0] read, [1] write and [2] execute. An in-range access whose kind is not permitted returns fault code 2 with `rsp_paddr` = 0. The reserved code is never permitted.
- R6: When an access is both out of range and not permitted, the fault code is 1 (bounds).
- R7: A table write with `priv_kernel` = 0 changes nothing. If no request is presented in that cycle, the next cycle gives a response with fault code 3 (privilege) and `rsp_ok` = 0. A request in the same cycle takes precedence over that report.
- R8: Each request yields `rsp_valid` = 1 exactly one clock later. `rsp_ok` is 1 only when `rsp_valid` is 1 and the fault code is 0. With no request and no user-mode write, `rsp_valid` is 0 in the next cycle.
- R9: After reset, `rsp_valid` is 0 and every slot has size 0 and no permissions, so every access returns fault code 1.
- R10: A kernel write to slot 3 has no effect; slot 3 keeps faulting as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | VA_W | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| cfg_we | input | 1 | Table write strobe |
| cfg_slot | input | 2 | Slot to write |
| cfg_base | input | PA_W | Base address to load |
| cfg_size | input | VA_W-1 | Segment size to load (0 to 2^(VA_W-2)) |
| cfg_down | input | 1 | 1 = segment grows downward |
| cfg_perm | input | 3 | Permissions: [0] read, [1] write, [2] execute |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_fault | output | 2 | 0 none, 1 bounds, 2 protection, 3 privilege |
| rsp_paddr | output | PA_W | Physical address; 0 on a fault |

## Verification
The bench builds the unit with VA_W = 8 and PA_W = 10. That gives 64-byte segments and 1024 distinct address and access-kind pairs, so each sweep covers every virtual address under every access kind. At this size every range edge is exercised. This includes the full-span downward segment, where offset 0 is legal, and a base close enough to the top of the physical space that the sum wraps. Between table changes, the sweeps are repeated after reset, after a rejected user-mode write, after a write to the spare slot and after reconfiguration.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_BOUNDS = 2'd1,
        FLT_PERM   = 2'd2,
        FLT_PRIV   = 2'd3
    } fault_e;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;
    localparam int NSLOT  = 4;
    localparam int SLOT_W = 2;
endpackage

// File: rtl/seg_table.sv
module seg_table
    import segxl_pkg::*;
#(
    parameter int PA_W = 20,
    parameter int SZ_W = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_kernel,
    input  logic [SLOT_W-1:0]          wr_slot,
    input  logic [PA_W-1:0]            wr_base,
    input  logic [SZ_W-1:0]            wr_size,
    input  logic                       wr_down,
    input  logic [2:0]                 wr_perm,
    input  logic [SLOT_W-1:0]          rd_slot,
    output logic [PA_W-1:0]            rd_base,
    output logic [SZ_W-1:0]            rd_size,
    output logic                       rd_down,
    output logic [2:0]                 rd_perm,
    output logic                       rd_live
);
    localparam int SPARE = NSLOT - 1;

    typedef struct packed {
        logic [PA_W-1:0] base;
        logic [SZ_W-1:0] size;
        logic            down;
        logic [2:0]      perm;
    } entry_t;

    entry_t [NSLOT-1:0] tbl_d, tbl_q;
    logic               wr_take;

    always_comb begin
        tbl_d   = tbl_q;
        wr_take = wr_en && wr_kernel && (wr_slot != SLOT_W'(SPARE));
        if (wr_take) begin
            tbl_d[wr_slot].base = wr_base;
            tbl_d[wr_slot].size = wr_size;
            tbl_d[wr_slot].down = wr_down;
            tbl_d[wr_slot].perm = wr_perm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign rd_base = tbl_q[rd_slot].base;
    assign rd_size = tbl_q[rd_slot].size;
    assign rd_down = tbl_q[rd_slot].down;
    assign rd_perm = tbl_q[rd_slot].perm;
    assign rd_live = (rd_slot != SLOT_W'(SPARE));

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot_chk
            // R7
            user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !wr_kernel) |=> $stable(tbl_q[g]));
        end
    endgenerate

    // R10
    spare_slot_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot == SLOT_W'(SPARE)) |=> (tbl_q[SPARE] == '0));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import segxl_pkg::*;
#(
    parameter int OFF_W = 14,
    parameter int PA_W  = 20
) (
    input  logic [OFF_W-1:0] offset,
    input  acc_e             acc,
    input  logic [PA_W-1:0]  base,
    input  logic [OFF_W:0]   size,
    input  logic             down,
    input  logic [2:0]       perm,
    input  logic             live,
    output fault_e           fault,
    output logic [PA_W-1:0]  paddr
);
    localparam logic [OFF_W:0] SPAN = {1'b1, {OFF_W{1'b0}}};

    logic [OFF_W:0] off_ext;
    logic [OFF_W:0] mag;
    logic           in_up, in_dn, in_rng, allowed;

    always_comb begin
        off_ext = {1'b0, offset};
        mag     = SPAN - off_ext;
        in_up   = off_ext < size;
        in_dn   = mag <= size;
        in_rng  = live && (down ? in_dn : in_up);

        unique case (acc)
            ACC_READ:  allowed = perm[PERM_R];
            ACC_WRITE: allowed = perm[PERM_W];
            ACC_EXEC:  allowed = perm[PERM_X];
            default:   allowed = 1'b0;
        endcase

        if (!in_rng)       fault = FLT_BOUNDS;
        else if (!allowed) fault = FLT_PERM;
        else               fault = FLT_NONE;

        if (fault != FLT_NONE) paddr = '0;
        else if (down)         paddr = base - PA_W'(mag);
        else                   paddr = base + PA_W'(off_ext);
    end
endmodule

// File: rtl/segxl_top.sv
module segxl_top
    import segxl_pkg::*;
#(
    parameter int VA_W = 16,
    parameter int PA_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            priv_kernel,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [1:0]      req_acc,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_slot,
    input  logic [PA_W-1:0] cfg_base,
    input  logic [VA_W-2:0] cfg_size,
    input  logic            cfg_down,
    input  logic [2:0]      cfg_perm,
    output logic            rsp_valid,
    output logic            rsp_ok,
    output logic [1:0]      rsp_fault,
    output logic [PA_W-1:0] rsp_paddr
);
    localparam int OFF_W = VA_W - SLOT_W;
    localparam int SZ_W  = OFF_W + 1;

    typedef struct packed {
        logic            valid;
        logic            ok;
        fault_e          fault;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [SLOT_W-1:0] slot;
    logic [OFF_W-1:0]  offset;
    logic [PA_W-1:0]   t_base;
    logic [SZ_W-1:0]   t_size;
    logic              t_down, t_live;
    logic [2:0]        t_perm;
    fault_e            x_fault;
    logic [PA_W-1:0]   x_paddr;
    logic              user_wr;

    assign slot   = req_vaddr[VA_W-1 -: SLOT_W];
    assign offset = req_vaddr[OFF_W-1:0];

    seg_table #(.PA_W(PA_W), .SZ_W(SZ_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_kernel (priv_kernel),
        .wr_slot   (cfg_slot),
        .wr_base   (cfg_base),
        .wr_size   (cfg_size),
        .wr_down   (cfg_down),
        .wr_perm   (cfg_perm),
        .rd_slot   (slot),
        .rd_base   (t_base),
        .rd_size   (t_size),
        .rd_down   (t_down),
        .rd_perm   (t_perm),
        .rd_live   (t_live)
    );

    seg_xlate #(.OFF_W(OFF_W), .PA_W(PA_W)) u_xlate (
        .offset (offset),
        .acc    (acc_e'(req_acc)),
        .base   (t_base),
        .size   (t_size),
        .down   (t_down),
        .perm   (t_perm),
        .live   (t_live),
        .fault  (x_fault),
        .paddr  (x_paddr)
    );

    always_comb begin
        user_wr     = cfg_we && !priv_kernel;
        rsp_d       = '0;
        rsp_d.valid = req_valid || user_wr;
        if (req_valid) begin
            rsp_d.fault = x_fault;
            rsp_d.paddr = x_paddr;
            rsp_d.ok    = (x_fault == FLT_NONE);
        end else if (user_wr) begin
            rsp_d.fault = FLT_PRIV;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_ok    = rsp_q.ok;
    assign rsp_fault = rsp_q.fault;
    assign rsp_paddr = rsp_q.paddr;

    // R8
    req_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R8
    ok_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> (rsp_valid && rsp_fault == 2'd0));
    // R4
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault != 2'd0) |-> (rsp_paddr == '0 && !rsp_ok));
    // R1
    spare_slot_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && slot == SLOT_W'(NSLOT - 1)) |=> (rsp_fault == 2'd1));
    // R7
    priv_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_we && !priv_kernel) |=> (rsp_fault != 2'd3));
endmodule

// File: tb/segxl_top_test.sv
module segxl_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int VA_W  = 8;
    localparam int PA_W  = 10;
    localparam int OFF_W = VA_W - 2;
    localparam int SPAN  = 1 << OFF_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            priv_kernel = 1'b0;
    logic            req_valid = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic [1:0]      req_acc = '0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_slot = '0;
    logic [PA_W-1:0] cfg_base = '0;
    logic [VA_W-2:0] cfg_size = '0;
    logic            cfg_down = 1'b0;
    logic [2:0]      cfg_perm = '0;
    logic            rsp_valid, rsp_ok;
    logic [1:0]      rsp_fault;
    logic [PA_W-1:0] rsp_paddr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_base [4];
    int m_size [4];
    int m_down [4];
    int m_perm [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    segxl_top #(.VA_W(VA_W), .PA_W(PA_W)) uut (
        .clk(clk), .rst_n(rst_n), .priv_kernel(priv_kernel),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_base(cfg_base),
        .cfg_size(cfg_size), .cfg_down(cfg_down), .cfg_perm(cfg_perm),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic cfg_write(input bit kern, input int s, input int b, input int sz,
                             input int dn, input int pm);
        @(negedge clk);
        priv_kernel = kern; cfg_we = 1'b1; cfg_slot = 2'(s);
        cfg_base = PA_W'(b); cfg_size = (VA_W-1)'(sz);
        cfg_down = dn[0]; cfg_perm = 3'(pm);
        if (kern && s != 3) begin
            m_base[s] = b; m_size[s] = sz; m_down[s] = dn; m_perm[s] = pm;
        end
        @(negedge clk);
        cfg_we = 1'b0; priv_kernel = 1'b1;
    endtask

    task automatic sweep(string phase_tag);
        for (int va = 0; va < (1 << VA_W); va++) begin
            for (int ac = 0; ac < 4; ac++) begin
                int s, o, mag, f, pa;
                bit inr, perm_ok;
                string tag;
                s = va >> OFF_W;
                o = va % SPAN;
                mag = SPAN - o;
                inr = (s != 3) && (m_down[s] != 0 ? (mag <= m_size[s]) : (o < m_size[s]));
                perm_ok = (ac < 3) && (((m_perm[s] >> ac) & 1) == 1);
                if (!inr)          f = 1;
                else if (!perm_ok) f = 2;
                else               f = 0;
                pa = 0;
                if (f == 0) pa = (m_down[s] != 0) ? ((m_base[s] + o - SPAN) & ((1 << PA_W) - 1))
                                                  : ((m_base[s] + o) & ((1 << PA_W) - 1));
                if (phase_tag != "")       tag = phase_tag;
                else if (s == 3)           tag = "R1";
                else if (!inr && !perm_ok) tag = "R6";
                else if (!inr)             tag = "R4";
                else if (!perm_ok)         tag = "R5";
                else if (m_down[s] != 0)   tag = "R3";
                else                       tag = "R2";
                @(negedge clk);
                req_valid = 1'b1; req_vaddr = VA_W'(va); req_acc = 2'(ac);
                @(posedge clk); #1;
                check(tag, {rsp_valid, rsp_ok, rsp_fault, rsp_paddr},
                      {1'b1, (f == 0), 2'(f), PA_W'(pa)}, $sformatf("va=%0h acc=%0d", va, ac));
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        check("R8", {31'b0, rsp_valid}, 32'd0, "idle valid");
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_base[i] = 0; m_size[i] = 0; m_down[i] = 0; m_perm[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R9", {31'b0, rsp_valid}, 32'd0, "valid in reset");
        rst_n = 1'b1;
        priv_kernel = 1'b1;
        @(negedge clk);
        check("R9", {31'b0, rsp_valid}, 32'd0, "valid after reset");
        sweep("R9");

        cfg_write(1, 0, 'h100, 40, 0, 5);
        cfg_write(1, 1, 'h3F0, 64, 0, 3);
        cfg_write(1, 2, 'h200, 20, 1, 3);
        sweep("");

        // R7: user write rejected and reported
        @(negedge clk);
        priv_kernel = 1'b0; cfg_we = 1'b1; cfg_slot = 2'd0;
        cfg_base = 'h2AA; cfg_size = 7'd64; cfg_down = 1'b1; cfg_perm = 3'd7;
        @(posedge clk); #1;
        check("R7", {rsp_valid, rsp_ok, rsp_fault, rsp_paddr}, {1'b1, 1'b0, 2'd3, PA_W'(0)}, "user write");
        // R7: request in same cycle wins
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 8'h05; req_acc = 2'd0;
        @(posedge clk); #1;
        check("R7", {rsp_valid, rsp_ok, rsp_fault, rsp_paddr},
              {1'b1, 1'b1, 2'd0, PA_W'('h105)}, "request over user write");
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0; priv_kernel = 1'b1;
        sweep("R7");

        // R10: kernel write to spare slot
        cfg_write(1, 3, 'h010, 64, 0, 7);
        sweep("R10");

        // new layout: full-span downward stack, empty heap, downward code
        cfg_write(1, 2, 'h080, 64, 1, 2);
        cfg_write(1, 1, 'h000, 0, 0, 0);
        cfg_write(1, 0, 'h3FF, 10, 1, 4);
        sweep("");
        check("R3", 32'(m_size[2]), 32'd64, "model span");

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule